// File: doc/BRIEF.md
# Banked Register AND Execute Unit

This block carries out one single-word instruction: it takes the working register (W), ANDs it with an 8-bit value from data memory, and stores the result either back into that memory location or into W. The instruction word is 16 bits wide. The block decodes it, works out the full data-memory address, reads the operand over a synchronous register-file port, and forms the result. It then writes the result and updates two status flags. Two opcode bits control the operation. A destination bit chooses where the result goes. A bank bit chooses how the address is built: from the access-bank map or from the bank-select register.

The work for one instruction is spread over one instruction cycle of four clock-long phases. The phases are, in order: decode, operand read, compute, and destination write. W, the status byte and the register file all live outside the block. The block receives their current values and drives write strobes and write data for them. A free-running phase counter is exposed so that the surrounding logic can present an instruction in the decode phase.

Top module: `bank_and_exec`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high in phase Q1 (`phase` = 0) and `instr[15:10]` = 6'b000101. In all other cases no read strobe and no write strobe of any kind is issued for that instruction cycle, and W, the status byte and the register file keep their values.
- R2: The result is `w_in` AND the operand byte that the register file returns during Q3. It appears on both `rf_wdata` and `w_wdata` during Q4.
- R3: When `instr[9]` = 0, `w_we` is high during Q4 and `rf_we` stays low. The memory location therefore keeps its value, and W takes the result.
- R4: When `instr[9]` = 1, `rf_we` is high during Q4 at the same address that was read, and `w_we` stays low. W therefore keeps its value, and the location takes the result.
- R5: When `instr[8]` = 0, the address is {4'h0, f} for f below 0x80 and {4'hF, f} for f of 0x80 or above, where f = `instr[7:0]`.
- R6: When `instr[8]` = 1, the address is {`bsr`, f}, using the value `bsr` has in Q1.
- R7: Status bit 2 (zero) of `status_wdata` is 1 exactly when the result is 0x00.
- R8: Status bit 4 (negative) of `status_wdata` equals bit 7 of the result.
- R9: The status byte has eight bits, with the flags at the bit positions given in R7 and R8. Every status bit other than 2 and 4 is copied unchanged from `status_in` as sampled in Q3.
- R10: The phase runs Q1, Q2, Q3, Q4 (encoded 0 to 3), starting at Q1 after reset. `rf_re` is high only in Q2. `rf_we`, `w_we` and `status_we` are high only in Q4, and `status_we` is high in Q4 of every accepted instruction.
- R11: With W = 0x17, an operand of 0xC2 and `instr[9]` = 0, W becomes 0x02, the location stays 0xC2, and the zero and negative flags are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present, sampled in Q1 |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank-select register value |
| w_in | input | 8 | Current working register |
| status_in | input | 8 | Current status byte |
| rf_rdata | input | 8 | Register-file read data, one cycle after `rf_re` |
| phase | output | 2 | Current phase, Q1=0 to Q4=3 |
| rf_re | output | 1 | Register-file read strobe |
| rf_addr | output | 12 | Register-file address for read and write |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| w_we | output | 1 | Working-register write strobe |
| w_wdata | output | 8 | Working-register write data |
| status_we | output | 1 | Status write strobe |
| status_wdata | output | 8 | New status byte |

## Verification
The destination write and the flag update always happen in the same Q4 cycle. The flags are computed from the same result that is being written. Every accepted instruction therefore creates this coincidence. The bench sweeps both destination settings and both address modes over W and operand values that give zero, non-zero, bit-7-set and bit-7-clear results. In Q4 it checks that exactly one destination strobe is high alongside the status strobe, and that the flags agree with the write data. In the following Q1 it checks that the untouched destination kept its earlier value.

// File: rtl/bank_and_pkg.sv
package bank_and_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam logic [5:0] OPC_AND_WF = 6'b000101;
  localparam int         FILE_W     = 8;
  localparam int         FLAG_Z     = 2;
  localparam int         FLAG_N     = 4;

  typedef struct packed {
    logic              hit;
    logic              to_file;
    logic              banked;
    logic [FILE_W-1:0] f;
  } and_dec_t;

endpackage

// File: rtl/bank_and_phase.sv
module bank_and_phase
  import bank_and_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e ph
);

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_Q1;
    else     ph <= phase_e'(ph + 2'd1);
  end

endmodule

// File: rtl/bank_and_decode.sv
module bank_and_decode
  import bank_and_pkg::*;
#(
  parameter int          BSR_W    = 4,
  parameter logic [3:0]  SFR_BANK = 4'hF,
  localparam int         ADDR_W   = BSR_W + FILE_W
) (
  input  logic              valid,
  input  logic [15:0]       word,
  input  logic [BSR_W-1:0]  bank_sel,
  output and_dec_t          dec,
  output logic [ADDR_W-1:0] addr
);

  logic [BSR_W-1:0] upper;

  always_comb begin
    dec.hit     = valid && (word[15:10] == OPC_AND_WF);
    dec.to_file = word[9];
    dec.banked  = word[8];
    dec.f       = word[7:0];
    if (dec.banked)
      upper = bank_sel;
    else if (dec.f[FILE_W-1])
      upper = BSR_W'(SFR_BANK);
    else
      upper = '0;
    addr = {upper, dec.f};
  end

endmodule

// File: rtl/bank_and_alu.sv
module bank_and_alu
  import bank_and_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8
) (
  input  logic [DATA_W-1:0] w_val,
  input  logic [DATA_W-1:0] opnd,
  input  logic [STAT_W-1:0] stat_old,
  output logic [DATA_W-1:0] res,
  output logic [STAT_W-1:0] stat_new
);

  always_comb begin
    res              = w_val & opnd;
    stat_new         = stat_old;
    stat_new[FLAG_Z] = (res == '0);
    stat_new[FLAG_N] = res[DATA_W-1];
  end

endmodule

// File: rtl/bank_and_exec.sv
module bank_and_exec
  import bank_and_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          STAT_W   = 8,
  parameter int          BSR_W    = 4,
  parameter logic [3:0]  SFR_BANK = 4'hF,
  localparam int         ADDR_W   = BSR_W + FILE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [BSR_W-1:0]  bsr,
  input  logic [DATA_W-1:0] w_in,
  input  logic [STAT_W-1:0] status_in,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [1:0]        phase,
  output logic              rf_re,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wdata,
  output logic              status_we,
  output logic [STAT_W-1:0] status_wdata
);

  phase_e            ph;
  and_dec_t          dec, dec_q;
  logic [ADDR_W-1:0] addr_c;
  logic [DATA_W-1:0] res_c, res_q;
  logic [STAT_W-1:0] stat_c;

  bank_and_phase u_phase (
    .clk (clk),
    .rst (rst),
    .ph  (ph)
  );

  bank_and_decode #(
    .BSR_W    (BSR_W),
    .SFR_BANK (SFR_BANK)
  ) u_dec (
    .valid    (instr_valid),
    .word     (instr),
    .bank_sel (bsr),
    .dec      (dec),
    .addr     (addr_c)
  );

  bank_and_alu #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
  ) u_alu (
    .w_val    (w_in),
    .opnd     (rf_rdata),
    .stat_old (status_in),
    .res      (res_c),
    .stat_new (stat_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q        <= '0;
      rf_re        <= 1'b0;
      rf_addr      <= '0;
      rf_we        <= 1'b0;
      w_we         <= 1'b0;
      status_we    <= 1'b0;
      res_q        <= '0;
      status_wdata <= '0;
    end else begin
      unique case (ph)
        PH_Q1: begin
          dec_q   <= dec;
          rf_addr <= addr_c;
          rf_re   <= dec.hit;
        end
        PH_Q2: rf_re <= 1'b0;
        PH_Q3: begin
          if (dec_q.hit) begin
            res_q        <= res_c;
            status_wdata <= stat_c;
            rf_we        <= dec_q.to_file;
            w_we         <= !dec_q.to_file;
            status_we    <= 1'b1;
          end
        end
        PH_Q4: begin
          rf_we     <= 1'b0;
          w_we      <= 1'b0;
          status_we <= 1'b0;
          dec_q.hit <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign phase    = ph;
  assign rf_wdata = res_q;
  assign w_wdata  = res_q;

endmodule

// File: rtl/bank_and_chk.sv
module bank_and_chk #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] w_in,
  input logic [STAT_W-1:0] status_in,
  input logic [DATA_W-1:0] rf_rdata,
  input logic [1:0]        phase,
  input logic              rf_re,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              w_we,
  input logic              status_we,
  input logic [STAT_W-1:0] status_wdata
);

  localparam logic [STAT_W-1:0] KEEP_MASK = ~(STAT_W'(1) << 2 | STAT_W'(1) << 4);

  assert_read_q2_R10: assert property (@(posedge clk) disable iff (rst)
    rf_re |-> phase == 2'd1);

  assert_write_q4_R10: assert property (@(posedge clk) disable iff (rst)
    (rf_we || w_we || status_we) |-> phase == 2'd3);

  assert_flags_with_dest_R10: assert property (@(posedge clk) disable iff (rst)
    status_we |-> $countones({rf_we, w_we}) == 1);

  assert_single_dest_R3: assert property (@(posedge clk) disable iff (rst)
    !(rf_we && w_we));

  assert_read_before_write_R4: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(rf_re, 2) && $stable(rf_addr));

  assert_and_result_R2: assert property (@(posedge clk) disable iff (rst)
    status_we |-> rf_wdata == ($past(w_in) & $past(rf_rdata)));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    status_we |-> status_wdata[2] == (rf_wdata == '0));

  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (rst)
    status_we |-> status_wdata[4] == rf_wdata[DATA_W-1]);

  assert_keep_bits_R9: assert property (@(posedge clk) disable iff (rst)
    status_we |-> (status_wdata & KEEP_MASK) == ($past(status_in) & KEEP_MASK));

endmodule

bind bank_and_exec bank_and_chk #(
  .DATA_W (DATA_W),
  .STAT_W (STAT_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .w_in         (w_in),
  .status_in    (status_in),
  .rf_rdata     (rf_rdata),
  .phase        (phase),
  .rf_re        (rf_re),
  .rf_addr      (rf_addr),
  .rf_we        (rf_we),
  .rf_wdata     (rf_wdata),
  .w_we         (w_we),
  .status_we    (status_we),
  .status_wdata (status_wdata)
);

// File: tb/bank_and_exec_tb.sv
`timescale 1ns/1ps
module bank_and_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic [7:0]  wreg;
  logic [7:0]  sreg;
  logic [7:0]  rf_rdata;
  logic [1:0]  phase;
  logic        rf_re, rf_we, w_we, status_we;
  logic [11:0] rf_addr;
  logic [7:0]  rf_wdata, w_wdata, status_wdata;
  logic [7:0]  mem [4096];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bank_and_exec dut_i (
    .clk          (clk),
    .rst          (rst),
    .instr_valid  (instr_valid),
    .instr        (instr),
    .bsr          (bsr),
    .w_in         (wreg),
    .status_in    (sreg),
    .rf_rdata     (rf_rdata),
    .phase        (phase),
    .rf_re        (rf_re),
    .rf_addr      (rf_addr),
    .rf_we        (rf_we),
    .rf_wdata     (rf_wdata),
    .w_we         (w_we),
    .w_wdata      (w_wdata),
    .status_we    (status_we),
    .status_wdata (status_wdata)
  );

  // Models of the register file, W and status around the block
  always @(posedge clk) begin
    if (rf_re) rf_rdata <= mem[rf_addr];
    if (rf_we) mem[rf_addr] <= rf_wdata;
    if (w_we) wreg <= w_wdata;
    if (status_we) sreg <= status_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic to_q1;
    do @(negedge clk); while (phase != 2'd0);
  endtask

  function automatic logic [11:0] exp_addr(input logic a, input logic [7:0] f,
                                           input logic [3:0] b);
    if (a) return {b, f};
    return f[7] ? {4'hF, f} : {4'h0, f};
  endfunction

  // One accepted instruction, checked in Q2, Q4 and the next Q1
  task automatic run_hit(input logic d, input logic a, input logic [7:0] f,
                         input logic [3:0] b);
    logic [11:0] ea;
    logic [7:0]  res, w0, m0, s0, sx;
    to_q1();
    ea = exp_addr(a, f, b);
    w0 = wreg; m0 = mem[ea]; s0 = sreg;
    res = w0 & m0;
    instr = {6'b000101, d, a, f}; bsr = b; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; bsr = ~b;
    chk(rf_re == 1'b1, "R10 read strobe in Q2", rf_re, 1);
    chk(rf_addr == ea, a ? "R6 banked address" : "R5 access address", rf_addr, ea);
    @(negedge clk);
    @(negedge clk);
    chk(status_we == 1'b1, "R10 status strobe in Q4", status_we, 1);
    chk({rf_we, w_we} == {d, !d}, d ? "R4 file strobe" : "R3 W strobe",
        {rf_we, w_we}, {d, !d});
    chk(rf_wdata == res, "R2 AND result", rf_wdata, res);
    chk(status_wdata[2] == (res == 8'h00), "R7 zero flag", status_wdata[2], res == 8'h00);
    chk(status_wdata[4] == res[7], "R8 negative flag", status_wdata[4], res[7]);
    sx = status_wdata & 8'hEB;
    chk(sx == (s0 & 8'hEB), "R9 other status bits kept", sx, s0 & 8'hEB);
    @(negedge clk);
    if (d) begin
      chk(mem[ea] == res, "R4 file takes result", mem[ea], res);
      chk(wreg == w0, "R4 W unchanged", wreg, w0);
    end else begin
      chk(wreg == res, "R3 W takes result", wreg, res);
      chk(mem[ea] == m0, "R3 file unchanged", mem[ea], m0);
    end
  endtask

  // One rejected instruction: nothing may move
  task automatic run_miss(input logic v, input logic [15:0] word);
    logic [7:0] w0, s0, m0;
    logic [11:0] ea;
    to_q1();
    ea = exp_addr(word[8], word[7:0], 4'h3);
    w0 = wreg; s0 = sreg; m0 = mem[ea];
    instr = word; bsr = 4'h3; instr_valid = v;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(rf_re == 1'b0, "R1 no read on reject", rf_re, 0);
    @(negedge clk);
    @(negedge clk);
    chk({rf_we, w_we, status_we} == 3'b000, "R1 no write on reject",
        {rf_we, w_we, status_we}, 0);
    @(negedge clk);
    chk(wreg == w0 && sreg == s0 && mem[ea] == m0, "R1 state kept on reject",
        {wreg, sreg, mem[ea]}, {w0, s0, m0});
  endtask

  initial begin
    logic [7:0] wv [5];
    logic [7:0] fv [4];
    wv = '{8'h00, 8'h17, 8'h80, 8'hFF, 8'h5A};
    fv = '{8'h05, 8'h7F, 8'h80, 8'hC3};
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 29) ^ (i >> 4));
    wreg = 8'h17; sreg = 8'hEB; rf_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(phase == 2'd0, "R10 starts in Q1", phase, 0);
    chk({rf_re, rf_we, w_we, status_we} == 4'b0, "R10 strobes idle after reset",
        {rf_re, rf_we, w_we, status_we}, 0);

    // R11: documented example
    mem[12'h005] = 8'hC2;
    wreg = 8'h17;
    run_hit(1'b0, 1'b0, 8'h05, 4'h0);
    chk(wreg == 8'h02, "R11 W result", wreg, 8'h02);
    chk(mem[12'h005] == 8'hC2, "R11 file unchanged", mem[12'h005], 8'hC2);
    chk(sreg[2] == 1'b0 && sreg[4] == 1'b0, "R11 flags clear", {sreg[4], sreg[2]}, 0);

    for (int wi = 0; wi < 5; wi++)
      for (int ai = 0; ai < 2; ai++)
        for (int di = 0; di < 2; di++)
          for (int fi = 0; fi < 4; fi++) begin
            to_q1();
            wreg = wv[wi];
            sreg = 8'(sreg ^ 8'h69);
            run_hit(di[0], ai[0], fv[fi], 4'(wi * 3 + fi + 1));
          end

    run_miss(1'b1, 16'h1005);
    run_miss(1'b1, 16'h1805);
    run_miss(1'b0, 16'h1605);
    run_miss(1'b1, 16'hE205);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule